// File: doc/BRIEF.md
# Floating-Point Condition Code Evaluator

This block classifies an 80-bit extended-precision result (a 16-bit sign/exponent word plus a 64-bit mantissa) into four condition flags (negative, zero, infinity and not-a-number) and keeps them in a status word. When the producer of the result pulses the valid strobe, the flags are replaced one clock later. Between strobes they hold.

A 6-bit condition selector picks one of sixteen floating-point predicates. These cover the ordered and unordered comparisons used by conditional branches and conditional sets. Each predicate is built from only the negative, zero and not-a-number flags. The chosen predicate appears combinationally on a single output bit. Selector values above 15 are reported as unsupported, and they force the predicate false.

For a conditional-set operation the block also returns a 32-bit data word. Its low byte is replaced by all ones when the predicate is true and by all zeros when it is false. Its upper 24 bits pass through unchanged.

Top module: `fpcc_eval`

## Requirements
- R1: After a synchronous active-low reset all four flags read 0, so `fstat` is 0, and code 2 (greater) evaluates true.
- R2: The N flag (status bit 27) copies bit 15 of the sign/exponent word.
- R3: The Z flag (status bit 26) is set when exponent bits 14:0 are all zero and mantissa bits 62:0 are all zero. Mantissa bit 63 is ignored.
- R4: The I flag (status bit 25) is set when exponent bits 14:0 equal 0x7FFF and mantissa bits 62:0 are all zero. Mantissa bit 63 is ignored.
- R5: The NaN flag (status bit 24) is set when exponent bits 14:0 equal 0x7FFF and mantissa bits 62:0 are not all zero.
- R6: All four flags are replaced together on the clock edge where `res_valid` is sampled high, so they are visible one cycle after the strobe. Without the strobe they hold, whatever the value inputs do.
- R7: Code 0 gives false, code 15 gives true, code 1 gives Z and code 14 gives not Z.
- R8: Ordered codes: 2 = !(NaN|Z|N), 3 = Z | !(NaN|N), 4 = N & !(NaN|Z), 5 = Z | (N & !NaN).
- R9: Codes 6 to 9: 6 = !NaN & !Z, 7 = !NaN, 8 = NaN, 9 = NaN | Z.
- R10: Unordered codes: 10 = NaN | !(N|Z), 11 = NaN | Z | !N, 12 = NaN | (N & !Z), 13 = NaN | Z | N.
- R11: Selector values 16 to 63 drive `cond_bad` high and `pred_true` low. Values 0 to 15 keep `cond_bad` low.
- R12: `dreg_out[7:0]` is 0xFF when `pred_true` is 1 and 0x00 when it is 0. `dreg_out[31:8]` equals `dreg_in[31:8]`.
- R13: All `fstat` bits other than 27:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Strobe: the result on the value inputs is to be classified |
| res_sexp | input | 16 | Sign (bit 15) and biased exponent (bits 14:0) of the result |
| res_mant | input | 64 | Mantissa of the result, explicit integer bit at 63 |
| cond_sel | input | 6 | Predicate selector |
| dreg_in | input | 32 | Data register value for the conditional-set merge |
| fstat | output | 32 | Status word holding the flags at bits 27:24 |
| pred_true | output | 1 | Selected predicate result |
| cond_bad | output | 1 | Selector is outside the supported codes |
| dreg_out | output | 32 | Data register with the conditional-set byte merged in |

## Verification
The only state in this block is the four-bit flag register. A wrong flag appears on `fstat` at the first sampling point after the clock edge that loaded it. In the same cycle it flips every predicate that depends on that flag, and with it the low byte of `dreg_out`. A flag that updates a cycle early or late, or that drifts while no strobe is present, is caught by comparing `fstat` just before and just after the strobed edge and across idle cycles. Sweeping all sixteen codes over each class of value (zero, negative, infinity, NaN) exposes a wrong predicate equation or a wrong flag position within one cycle.

// File: rtl/fpcc_pkg.sv
// Package: shared flag type and predicate equations for the
// floating-point condition code evaluator.
// Assumes: predicate codes are 4 bits wide; wider selectors are
// range-checked by the caller.
package fpcc_pkg;

    // Number of supported predicate codes
    localparam int PRED_N = 16;
    // Bits needed to index them
    localparam int CODE_W = $clog2(PRED_N);
    // Number of condition flags
    localparam int FLAG_N = 4;

    // Condition flags, most significant first: negative, zero, infinity, NaN
    typedef struct packed {
        logic neg;
        logic zer;
        logic inf;
        logic nan;
    } fcc_t;

    // Evaluate one predicate code against the flags (infinity flag unused)
    function automatic logic eval_code(input logic [CODE_W-1:0] code,
                                       input fcc_t f);
        logic r;
        case (code)
            4'd0:    r = 1'b0;
            4'd1:    r = f.zer;
            4'd2:    r = !(f.nan || f.zer || f.neg);
            4'd3:    r = f.zer || !(f.nan || f.neg);
            4'd4:    r = f.neg && !(f.nan || f.zer);
            4'd5:    r = f.zer || (f.neg && !f.nan);
            4'd6:    r = !f.nan && !f.zer;
            4'd7:    r = !f.nan;
            4'd8:    r = f.nan;
            4'd9:    r = f.nan || f.zer;
            4'd10:   r = f.nan || !(f.neg || f.zer);
            4'd11:   r = f.nan || f.zer || !f.neg;
            4'd12:   r = f.nan || (f.neg && !f.zer);
            4'd13:   r = f.nan || f.zer || f.neg;
            4'd14:   r = !f.zer;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpcc_classify.sv
// Module: fpcc_classify
// Classifies an extended-precision value into the four condition flags.
// Assumes: the sign sits just above the exponent field, and the top
// mantissa bit is the explicit integer bit. That bit is ignored by the
// zero, infinity and NaN tests.
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int MANT_W = 64
) (
    input  logic [EXP_W:0]    sexp,
    input  logic [MANT_W-1:0] mant,
    output fcc_t              cls
);

    localparam int FRAC_W = MANT_W - 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              frac_zero;
    logic              exp_zero;
    logic              exp_max;

    // Split the fields; the integer bit is dropped here
    always_comb begin
        expo      = sexp[EXP_W-1:0];
        frac      = mant[FRAC_W-1:0];
        frac_zero = ~|frac;
        exp_zero  = ~|expo;
        exp_max   = &expo;
    end

    // Form the flags from the field tests
    always_comb begin
        cls.neg = sexp[EXP_W];
        cls.zer = exp_zero && frac_zero;
        cls.inf = exp_max && frac_zero;
        cls.nan = exp_max && !frac_zero;
    end

endmodule

// File: rtl/fpcc_flagreg.sv
// Module: fpcc_flagreg
// Holds the condition flags. All four are replaced together on a strobed
// edge and hold otherwise.
// Assumes: synchronous active-low reset clears the flags.
module fpcc_flagreg
    import fpcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  fcc_t cls_in,
    output fcc_t flags
);

    // Flag register: clear on reset, replace on strobe, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (load) begin
            flags <= cls_in;
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags)); // R6

    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.zer, flags.inf, flags.nan})); // R3

    AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (flags == $past(cls_in))); // R6

endmodule

// File: rtl/fpcc_predicate.sv
// Module: fpcc_predicate
// Evaluates all sixteen predicates in parallel and selects one by code.
// Selector values outside the table flag an unsupported condition and
// force the result false.
// Assumes: SEL_W is wider than the code index.
module fpcc_predicate
    import fpcc_pkg::*;
#(
    parameter int SEL_W = 6
) (
    input  fcc_t             flags,
    input  logic [SEL_W-1:0] sel,
    output logic             pred,
    output logic             bad
);

    logic [PRED_N-1:0] table_v;

    // One evaluator per predicate code
    for (genvar g = 0; g < PRED_N; g++) begin : g_code
        assign table_v[g] = eval_code(CODE_W'(g), flags);
    end

    // Range check on the selector and final pick
    always_comb begin
        bad  = |sel[SEL_W-1:CODE_W];
        pred = !bad && table_v[sel[CODE_W-1:0]];
    end

endmodule

// File: rtl/fpcc_setbyte.sv
// Module: fpcc_setbyte
// Merges the all-ones or all-zeros conditional-set byte into the low
// byte of a data word. The upper bits pass through.
// Assumes: BYTE_W is smaller than WORD_W.
module fpcc_setbyte #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              pred,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    // Replace the low byte, keep the rest
    always_comb begin
        dout = {din[WORD_W-1:BYTE_W], {BYTE_W{pred}}};
    end

endmodule

// File: rtl/fpcc_eval.sv
// Module: fpcc_eval (top)
// Floating-point condition code evaluator: classifies a strobed result,
// keeps the flags in a status word, and evaluates the selected predicate.
// It also produces the conditional-set merge of a data word.
// Assumes: synchronous active-low reset, and a single clock domain.
module fpcc_eval
    import fpcc_pkg::*;
#(
    parameter int EXP_W    = 15,
    parameter int MANT_W   = 64,
    parameter int SEL_W    = 6,
    parameter int WORD_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int FLAG_LSB = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [EXP_W:0]      res_sexp,
    input  logic [MANT_W-1:0]   res_mant,
    input  logic [SEL_W-1:0]    cond_sel,
    input  logic [WORD_W-1:0]   dreg_in,
    output logic [WORD_W-1:0]   fstat,
    output logic                pred_true,
    output logic                cond_bad,
    output logic [WORD_W-1:0]   dreg_out
);

    fcc_t cls_w;
    fcc_t flags_q;

    // Classify the incoming value
    fpcc_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cls (
        .sexp (res_sexp),
        .mant (res_mant),
        .cls  (cls_w)
    );

    // Hold the flags
    fpcc_flagreg u_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (res_valid),
        .cls_in (cls_w),
        .flags  (flags_q)
    );

    // Evaluate the selected predicate
    fpcc_predicate #(.SEL_W(SEL_W)) u_prd (
        .flags (flags_q),
        .sel   (cond_sel),
        .pred  (pred_true),
        .bad   (cond_bad)
    );

    // Merge the conditional-set byte
    fpcc_setbyte #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_set (
        .pred (pred_true),
        .din  (dreg_in),
        .dout (dreg_out)
    );

    // Place the flags in the status word, other bits zero
    always_comb begin
        fstat = '0;
        fstat[FLAG_LSB +: FLAG_N] = flags_q;
    end

    AST_BAD_FORCES_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_bad |-> !pred_true); // R11

    AST_CODE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == SEL_W'(15)) |-> pred_true); // R7

    AST_CODE_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == '0) |-> !pred_true); // R7

    AST_SET_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dreg_out[BYTE_W-1:0] == {BYTE_W{pred_true}}); // R12

    AST_SET_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dreg_out[WORD_W-1:BYTE_W] == dreg_in[WORD_W-1:BYTE_W]); // R12

    AST_STATUS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (fstat[FLAG_LSB+FLAG_N-1] == $past(res_sexp[EXP_W]))); // R2

endmodule

// File: tb/fpcc_eval_test.sv
module fpcc_eval_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_sexp = '0;
    logic [63:0] res_mant = '0;
    logic [5:0]  cond_sel = '0;
    logic [31:0] dreg_in = '0;
    logic [31:0] fstat;
    logic        pred_true;
    logic        cond_bad;
    logic [31:0] dreg_out;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fpcc_eval uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
        .res_sexp(res_sexp), .res_mant(res_mant), .cond_sel(cond_sel),
        .dreg_in(dreg_in), .fstat(fstat), .pred_true(pred_true),
        .cond_bad(cond_bad), .dreg_out(dreg_out)
    );

    // Value vectors: sign/exponent and mantissa
    logic [15:0] vx [11] = '{16'h0000, 16'h8000, 16'h3FFF, 16'hBFFF, 16'h7FFF,
                             16'hFFFF, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0000,
                             16'h7FFE};
    logic [63:0] vm [11] = '{64'h0, 64'h0, 64'h8000_0000_0000_0000,
                             64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
                             64'h0, 64'hC000_0000_0000_0000, 64'h1,
                             64'h8000_0000_0000_0000, 64'h1,
                             64'hFFFF_FFFF_FFFF_FFFF};

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Expected status word from R2..R5 and R13
    function automatic logic [31:0] exp_stat(input logic [15:0] sx, input logic [63:0] m);
        logic [14:0] e = sx[14:0];
        logic lz = (m[62:0] == 63'd0);
        logic n = sx[15];
        logic z = (e == 15'd0) && lz;
        logic i = (e == 15'h7FFF) && lz;
        logic q = (e == 15'h7FFF) && !lz;
        return {4'b0, n, z, i, q, 24'b0};
    endfunction

    // Expected predicate from R7..R10, flags taken from a status word
    function automatic logic exp_pred(input int code, input logic [31:0] st);
        logic n = st[27];
        logic z = st[26];
        logic q = st[24];
        case (code)
            0: return 1'b0;
            1: return z;
            2: return !(q | z | n);
            3: return z | !(q | n);
            4: return n & !(q | z);
            5: return z | (n & !q);
            6: return !q & !z;
            7: return !q;
            8: return q;
            9: return q | z;
            10: return q | !(n | z);
            11: return q | z | !n;
            12: return q | (n & !z);
            13: return q | z | n;
            14: return !z;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string code_tag(input int code);
        if (code == 0 || code == 1 || code == 14 || code == 15) return "R7";
        if (code <= 5) return "R8";
        if (code <= 9) return "R9";
        return "R10";
    endfunction

    // Strobe one value; flags are valid at the returned negedge
    task automatic load_val(input logic [15:0] sx, input logic [63:0] m);
        @(negedge clk);
        res_sexp = sx; res_mant = m; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cond_sel = 6'd2;
        #1;
        chk(fstat == 32'd0, "R1 status after reset", 64'(fstat), 64'd0);
        chk(pred_true == 1'b1, "R1 greater true after reset", 64'(pred_true), 64'd1);
    endtask

    task automatic t_classify;
        for (int k = 0; k < 11; k++) begin
            load_val(vx[k], vm[k]);
            #1;
            chk(fstat == exp_stat(vx[k], vm[k]), "R2 R3 R4 R5 R13 status flags",
                64'(fstat), 64'(exp_stat(vx[k], vm[k])));
        end
    endtask

    task automatic t_timing;
        load_val(16'h3FFF, 64'h8000_0000_0000_0000);
        @(negedge clk);
        res_sexp = 16'h8000; res_mant = 64'h0; res_valid = 1'b1;
        #1;
        chk(fstat == 32'd0, "R6 no change before edge", 64'(fstat), 64'd0);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        chk(fstat == 32'h0C00_0000, "R6 update after edge", 64'(fstat), 64'h0C00_0000);
        res_sexp = 16'h7FFF; res_mant = 64'h1;
        repeat (3) @(negedge clk);
        #1;
        chk(fstat == 32'h0C00_0000, "R6 hold without strobe", 64'(fstat), 64'h0C00_0000);
    endtask

    task automatic t_predicates;
        int picks [7] = '{0, 1, 2, 3, 5, 6, 7};
        for (int p = 0; p < 7; p++) begin
            load_val(vx[picks[p]], vm[picks[p]]);
            dreg_in = 32'hA5C3_1E00 ^ 32'(p * 32'h0101_0111);
            for (int c = 0; c < 16; c++) begin
                cond_sel = 6'(c);
                #1;
                chk(pred_true == exp_pred(c, exp_stat(vx[picks[p]], vm[picks[p]])),
                    code_tag(c), 64'(pred_true),
                    64'(exp_pred(c, exp_stat(vx[picks[p]], vm[picks[p]]))));
                chk(dreg_out == {dreg_in[31:8], {8{exp_pred(c, exp_stat(vx[picks[p]], vm[picks[p]]))}}},
                    "R12 set byte merge", 64'(dreg_out),
                    64'({dreg_in[31:8], {8{exp_pred(c, exp_stat(vx[picks[p]], vm[picks[p]]))}}}));
                #1;
            end
        end
    endtask

    task automatic t_bad_sel;
        load_val(16'h0000, 64'h0);
        for (int s = 0; s < 64; s++) begin
            cond_sel = 6'(s);
            #1;
            if (s >= 16) begin
                chk(cond_bad == 1'b1, "R11 unsupported flagged", 64'(cond_bad), 64'd1);
                chk(pred_true == 1'b0, "R11 unsupported forces false", 64'(pred_true), 64'd0);
            end else begin
                chk(cond_bad == 1'b0, "R11 supported not flagged", 64'(cond_bad), 64'd0);
            end
            #1;
        end
        cond_sel = 6'd0;
    endtask

    initial begin
        #2_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_classify();
        t_timing();
        t_predicates();
        t_bad_sel();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule